// File: doc/BRIEF.md
# Overlap-Safe Rectangle Blitter

This block performs two drawing operations on a linear, byte-addressed framebuffer held in an external single-port synchronous RAM: a solid rectangle fill and a rectangle-to-rectangle copy. Every framebuffer row is `cfg_pitch` bytes apart and each pixel is `cfg_bpp` bytes wide. The copy picks its row order and its byte order within a row from the relative positions of source and destination. As a result, a copy whose source and destination overlap gives the same picture as a copy taken from an untouched snapshot of the source.

Each finished operation records its destination rectangle in a ring of pending screen updates. A consumer holds `drain_en` high to take those rectangles out one per cycle, oldest first. Each rectangle is clipped against the current screen size as it is taken out. Pulsing `invalidate` throws away everything pending, for the case where the whole screen will be repainted anyway.

The RAM returns read data one cycle after a read is issued. The block owns the RAM port whenever it is busy.

Top module: `rect_blitter`

## Requirements
- R1: A fill writes, for every pixel (x+i, y+j) of the rectangle, byte k (k = 0 .. cfg_bpp-1) of `cmd_colour` (bits 8k+7:8k) to address cfg_bpp·(x+i) + cfg_pitch·(y+j) + k. No other byte changes. `cmd_op` = 0 selects fill. `cfg_bpp` ranges from 1 to 4.
- R2: A copy (`cmd_op` = 1) leaves the destination rectangle equal to the source rectangle as it was before the command. This holds when the rectangles overlap and the destination lies lower (dst_y > src_y); the rows are then processed from the bottom row upward.
- R3: The copy is also exact when overlapping with dst_y < src_y (rows top down). It is exact when dst_y = src_y, both for dst_x > src_x (bytes right to left) and for dst_x < src_x (bytes left to right).
- R4: A command with zero width or zero height performs no RAM write. It asserts `done` in the cycle after acceptance and still records its rectangle.
- R5: `cmd_ready` is high only when idle. `busy` is high from the cycle after a non-empty command is accepted through the cycle of its last RAM write. `done` is a one-cycle pulse in the following cycle. A fill of N bytes thus shows `done` N+1 cycles after acceptance, and a copy of N bytes 2N+1 cycles after.
- R6: In the `done` cycle, the destination rectangle (dst x, y, w, h) is appended to the pending-update ring.
- R7: While `drain_en` is high and the ring is not empty, one entry leaves per clock in arrival order. It appears on `drain_*` with `drain_valid` in the following cycle.
- R8: On removal, if x + w > `scr_w`, then x becomes min(x, `scr_w`) and w becomes `scr_w` − x. The same rule applies to y, h and `scr_h`.
- R9: The ring holds QDEPTH = 512 entries. A push into a full ring overwrites the oldest entry, so the newest 512 remain.
- R10: `invalidate` empties the ring at the next edge. A rectangle pushed on that same edge is kept as the only entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command accepted when valid |
| cmd_op | input | 1 | 0 fill, 1 copy |
| cmd_src_x | input | COORD_W | Copy source left column |
| cmd_src_y | input | COORD_W | Copy source top row |
| cmd_dst_x | input | COORD_W | Destination left column |
| cmd_dst_y | input | COORD_W | Destination top row |
| cmd_w | input | COORD_W | Width in pixels |
| cmd_h | input | COORD_W | Height in rows |
| cmd_colour | input | 32 | Fill value, low byte first |
| cfg_pitch | input | PITCH_W | Bytes per framebuffer row |
| cfg_bpp | input | 3 | Bytes per pixel, 1 to 4 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_en | output | 1 | RAM access strobe |
| mem_we | output | 1 | RAM write (else read) |
| mem_addr | output | ADDR_W | RAM byte address |
| mem_wdata | output | 8 | RAM write byte |
| mem_rdata | input | 8 | RAM read byte, one cycle after read |
| scr_w | input | COORD_W | Screen width for clipping |
| scr_h | input | COORD_W | Screen height for clipping |
| invalidate | input | 1 | Discard pending updates |
| drain_en | input | 1 | Remove pending updates |
| drain_valid | output | 1 | Drain outputs carry an entry |
| drain_x | output | COORD_W | Clipped x |
| drain_y | output | COORD_W | Clipped y |
| drain_w | output | COORD_W | Clipped width |
| drain_h | output | COORD_W | Clipped height |

## Verification
The ring can see a push from a finishing operation in the same edge as an invalidate. The same holds for a push while a drain is removing entries. The bench provokes the first case by waiting for the `done` pulse of a zero-area fill and raising `invalidate` for exactly that cycle. It then expects a drain to return that one rectangle and nothing older. Overflow is provoked with 515 zero-area pushes, after which the drain must return exactly the last 512 in order.

// File: rtl/blit_pkg.sv
package blit_pkg;
    parameter int COORD_W = 12;

    typedef logic [COORD_W-1:0] coord_t;

    typedef struct packed {
        coord_t x;
        coord_t y;
        coord_t w;
        coord_t h;
    } rect_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_RD,
        ST_WR,
        ST_FIN
    } blit_st_e;

    // Clip one axis: if start+len passes the limit, pull start to the limit
    // and shorten the length to what remains.
    function automatic logic [2*COORD_W-1:0] clip_axis(coord_t s, coord_t l, coord_t lim);
        logic [COORD_W:0] endp;
        coord_t s_o;
        coord_t l_o;
        endp = {1'b0, s} + {1'b0, l};
        s_o  = s;
        l_o  = l;
        if (endp > {1'b0, lim}) begin
            s_o = (s < lim) ? s : lim;
            l_o = lim - s_o;
        end
        return {s_o, l_o};
    endfunction
endpackage

// File: rtl/blit_clip.sv
module blit_clip
    import blit_pkg::*;
(
    input  rect_t  in_rect,
    input  coord_t lim_w,
    input  coord_t lim_h,
    output rect_t  out_rect
);
    logic [2*COORD_W-1:0] xs;
    logic [2*COORD_W-1:0] ys;

    always_comb begin
        xs = clip_axis(in_rect.x, in_rect.w, lim_w);
        ys = clip_axis(in_rect.y, in_rect.h, lim_h);
        out_rect.x = xs[2*COORD_W-1:COORD_W];
        out_rect.w = xs[COORD_W-1:0];
        out_rect.y = ys[2*COORD_W-1:COORD_W];
        out_rect.h = ys[COORD_W-1:0];
    end
endmodule

// File: rtl/blit_dirty_ring.sv
module blit_dirty_ring
    import blit_pkg::*;
#(
    parameter int QDEPTH = 512
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   push,
    input  rect_t  push_rect,
    input  logic   inval,
    input  logic   drain_en,
    input  coord_t lim_w,
    input  coord_t lim_h,
    output logic   drain_valid,
    output rect_t  drain_rect
);
    localparam int PTR_W = $clog2(QDEPTH);

    rect_t            slots [QDEPTH];
    logic [PTR_W-1:0] head;
    logic [PTR_W-1:0] tail;
    logic [PTR_W:0]   count;
    logic             full;
    logic             pop;
    rect_t            clipped;

    assign full = (count == (PTR_W+1)'(QDEPTH));
    assign pop  = drain_en && (count != '0) && !inval;

    blit_clip u_clip (
        .in_rect (slots[head]),
        .lim_w   (lim_w),
        .lim_h   (lim_h),
        .out_rect(clipped)
    );

    always_ff @(posedge clk) begin
        if (push) slots[tail] <= push_rect;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head        <= '0;
            tail        <= '0;
            count       <= '0;
            drain_valid <= 1'b0;
            drain_rect  <= '0;
        end else begin
            drain_valid <= pop;
            if (pop) drain_rect <= clipped;
            if (push) tail <= tail + 1'b1;
            if (inval) begin
                head  <= tail;
                count <= push ? (PTR_W+1)'(1) : '0;
            end else begin
                if (pop || (push && full)) head <= head + 1'b1;
                if (push && !pop && !full) count <= count + 1'b1;
                else if (pop && !push)     count <= count - 1'b1;
            end
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        count <= (PTR_W+1)'(QDEPTH)); // R9
    AST_FULL_KEEP: assert property (@(posedge clk) disable iff (rst)
        full && push && !pop && !inval |=> full); // R9
    AST_INVAL_EMPTY: assert property (@(posedge clk) disable iff (rst)
        inval && !push |=> (count == '0) && (head == tail)); // R10
    AST_INVAL_KEEP_PUSH: assert property (@(posedge clk) disable iff (rst)
        inval && push |=> (count == (PTR_W+1)'(1))); // R10
    AST_DRAIN_REQ: assert property (@(posedge clk) disable iff (rst)
        drain_valid |-> $past(drain_en)); // R7
endmodule

// File: rtl/blit_engine.sv
module blit_engine
    import blit_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int PITCH_W = 14
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic               cmd_op,
    input  coord_t             src_x,
    input  coord_t             src_y,
    input  coord_t             dst_x,
    input  coord_t             dst_y,
    input  coord_t             wid,
    input  coord_t             hgt,
    input  logic [31:0]        colour,
    input  logic [PITCH_W-1:0] pitch,
    input  logic [2:0]         bpp,
    output logic               busy,
    output logic               done,
    output logic               mem_en,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [7:0]         mem_wdata,
    input  logic [7:0]         mem_rdata,
    output logic               push,
    output rect_t              push_rect
);
    localparam int RB_W = COORD_W + 3;

    blit_st_e          st;
    logic [31:0]       colour_r;
    logic [2:0]        bpp_r;
    logic [ADDR_W-1:0] pitch_r;
    logic [RB_W-1:0]   col;
    logic [RB_W-1:0]   col_last;
    coord_t            rows_left;
    logic [1:0]        bsel;
    logic [ADDR_W-1:0] sbase;
    logic [ADDR_W-1:0] dbase;
    logic              asc;
    logic              desc;
    rect_t             rect_r;

    // Set-up values computed at accept time.
    logic              zero_sz;
    logic              n_desc;
    logic              n_asc;
    logic [RB_W-1:0]   n_rowbytes;
    coord_t            n_sy;
    coord_t            n_dy;
    logic [ADDR_W-1:0] n_sbase;
    logic [ADDR_W-1:0] n_dbase;

    always_comb begin
        zero_sz    = (wid == '0) || (hgt == '0);
        n_desc     = cmd_op && (dst_y > src_y);
        n_asc      = !cmd_op || (dst_x <= src_x);
        n_rowbytes = RB_W'(wid) * RB_W'(bpp);
        n_sy       = n_desc ? (src_y + hgt - 1'b1) : src_y;
        n_dy       = n_desc ? (dst_y + hgt - 1'b1) : dst_y;
        n_sbase    = ADDR_W'(src_x) * ADDR_W'(bpp) + ADDR_W'(pitch) * ADDR_W'(n_sy);
        n_dbase    = ADDR_W'(dst_x) * ADDR_W'(bpp) + ADDR_W'(pitch) * ADDR_W'(n_dy);
    end

    logic row_end;
    logic last_step;
    logic stepping;

    assign row_end   = asc ? (col == col_last) : (col == '0);
    assign last_step = row_end && (rows_left == coord_t'(1));
    assign stepping  = (st == ST_FILL) || (st == ST_WR);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            colour_r  <= '0;
            bpp_r     <= '0;
            pitch_r   <= '0;
            col       <= '0;
            col_last  <= '0;
            rows_left <= '0;
            bsel      <= '0;
            sbase     <= '0;
            dbase     <= '0;
            asc       <= 1'b1;
            desc      <= 1'b0;
            rect_r    <= '0;
        end else begin
            unique case (st)
                ST_IDLE: if (cmd_valid) begin
                    colour_r  <= colour;
                    bpp_r     <= bpp;
                    pitch_r   <= ADDR_W'(pitch);
                    col_last  <= n_rowbytes - 1'b1;
                    col       <= n_asc ? '0 : (n_rowbytes - 1'b1);
                    rows_left <= hgt;
                    bsel      <= '0;
                    sbase     <= n_sbase;
                    dbase     <= n_dbase;
                    asc       <= n_asc;
                    desc      <= n_desc;
                    rect_r    <= '{x: dst_x, y: dst_y, w: wid, h: hgt};
                    if (zero_sz)     st <= ST_FIN;
                    else if (cmd_op) st <= ST_RD;
                    else             st <= ST_FILL;
                end
                ST_FILL: if (last_step) st <= ST_FIN;
                ST_RD:   st <= ST_WR;
                ST_WR:   st <= last_step ? ST_FIN : ST_RD;
                ST_FIN:  st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase

            if (stepping) begin
                if (row_end) begin
                    col       <= asc ? '0 : col_last;
                    bsel      <= '0;
                    rows_left <= rows_left - 1'b1;
                    sbase     <= desc ? (sbase - pitch_r) : (sbase + pitch_r);
                    dbase     <= desc ? (dbase - pitch_r) : (dbase + pitch_r);
                end else begin
                    col  <= asc ? (col + 1'b1) : (col - 1'b1);
                    bsel <= ({1'b0, bsel} == bpp_r - 3'd1) ? 2'd0 : (bsel + 2'd1);
                end
            end
        end
    end

    assign cmd_ready = (st == ST_IDLE);
    assign busy      = (st == ST_FILL) || (st == ST_RD) || (st == ST_WR);
    assign done      = (st == ST_FIN);
    assign push      = (st == ST_FIN);
    assign push_rect = rect_r;
    assign mem_en    = busy;
    assign mem_we    = stepping;
    assign mem_addr  = (st == ST_RD) ? (sbase + ADDR_W'(col)) : (dbase + ADDR_W'(col));
    assign mem_wdata = (st == ST_FILL) ? colour_r[{bsel, 3'b000} +: 8] : mem_rdata;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R5
    AST_BUSY_TO_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done); // R5
    AST_ZERO_NO_WORK: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_ready && ((wid == '0) || (hgt == '0)) |=> done && !mem_en); // R4
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_ready && (wid != '0) && (hgt != '0) |=> busy); // R5
    AST_DESC_ROWS: assert property (@(posedge clk) disable iff (rst)
        stepping && row_end && !last_step && desc |=> (dbase == $past(dbase) - pitch_r)); // R2
endmodule

// File: rtl/rect_blitter.sv
module rect_blitter
    import blit_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int PITCH_W = 14,
    parameter int QDEPTH  = 512
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic               cmd_op,
    input  logic [COORD_W-1:0] cmd_src_x,
    input  logic [COORD_W-1:0] cmd_src_y,
    input  logic [COORD_W-1:0] cmd_dst_x,
    input  logic [COORD_W-1:0] cmd_dst_y,
    input  logic [COORD_W-1:0] cmd_w,
    input  logic [COORD_W-1:0] cmd_h,
    input  logic [31:0]        cmd_colour,
    input  logic [PITCH_W-1:0] cfg_pitch,
    input  logic [2:0]         cfg_bpp,
    output logic               busy,
    output logic               done,
    output logic               mem_en,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [7:0]         mem_wdata,
    input  logic [7:0]         mem_rdata,
    input  logic [COORD_W-1:0] scr_w,
    input  logic [COORD_W-1:0] scr_h,
    input  logic               invalidate,
    input  logic               drain_en,
    output logic               drain_valid,
    output logic [COORD_W-1:0] drain_x,
    output logic [COORD_W-1:0] drain_y,
    output logic [COORD_W-1:0] drain_w,
    output logic [COORD_W-1:0] drain_h
);
    logic  push;
    rect_t push_rect;
    rect_t drain_rect;

    blit_engine #(.ADDR_W(ADDR_W), .PITCH_W(PITCH_W)) u_engine (
        .clk      (clk),
        .rst      (rst),
        .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready),
        .cmd_op   (cmd_op),
        .src_x    (cmd_src_x),
        .src_y    (cmd_src_y),
        .dst_x    (cmd_dst_x),
        .dst_y    (cmd_dst_y),
        .wid      (cmd_w),
        .hgt      (cmd_h),
        .colour   (cmd_colour),
        .pitch    (cfg_pitch),
        .bpp      (cfg_bpp),
        .busy     (busy),
        .done     (done),
        .mem_en   (mem_en),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata),
        .push     (push),
        .push_rect(push_rect)
    );

    blit_dirty_ring #(.QDEPTH(QDEPTH)) u_ring (
        .clk        (clk),
        .rst        (rst),
        .push       (push),
        .push_rect  (push_rect),
        .inval      (invalidate),
        .drain_en   (drain_en),
        .lim_w      (scr_w),
        .lim_h      (scr_h),
        .drain_valid(drain_valid),
        .drain_rect (drain_rect)
    );

    assign drain_x = drain_rect.x;
    assign drain_y = drain_rect.y;
    assign drain_w = drain_rect.w;
    assign drain_h = drain_rect.h;
endmodule

// File: tb/rect_blitter_tb_top.sv
module rect_blitter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int FBSZ = 4096;
    localparam int PITCH = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic        cmd_op = 1'b0;
    logic [11:0] cmd_src_x = '0, cmd_src_y = '0, cmd_dst_x = '0, cmd_dst_y = '0;
    logic [11:0] cmd_w = '0, cmd_h = '0;
    logic [31:0] cmd_colour = '0;
    logic [13:0] cfg_pitch = 14'(PITCH);
    logic [2:0]  cfg_bpp = 3'd1;
    logic        busy, done, mem_en, mem_we;
    logic [19:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic [11:0] scr_w = 12'd20, scr_h = 12'd12;
    logic        invalidate = 1'b0;
    logic        drain_en = 1'b0;
    logic        drain_valid;
    logic [11:0] drain_x, drain_y, drain_w, drain_h;

    int n_chk = 0;
    int n_bad = 0;
    int we_cnt = 0;

    logic [7:0]  fb  [FBSZ];
    logic [7:0]  expm[FBSZ];
    logic [47:0] expq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rect_blitter dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_src_x(cmd_src_x), .cmd_src_y(cmd_src_y),
        .cmd_dst_x(cmd_dst_x), .cmd_dst_y(cmd_dst_y), .cmd_w(cmd_w), .cmd_h(cmd_h),
        .cmd_colour(cmd_colour), .cfg_pitch(cfg_pitch), .cfg_bpp(cfg_bpp),
        .busy(busy), .done(done), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .scr_w(scr_w), .scr_h(scr_h), .invalidate(invalidate), .drain_en(drain_en),
        .drain_valid(drain_valid), .drain_x(drain_x), .drain_y(drain_y),
        .drain_w(drain_w), .drain_h(drain_h)
    );

    // Single-port synchronous RAM model, preset with a pattern in reset.
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < FBSZ; i++) fb[i] <= 8'(i * 7 + 3);
        end else if (mem_en) begin
            if (mem_we) begin
                fb[mem_addr[11:0]] <= mem_wdata;
                we_cnt <= we_cnt + 1;
            end else begin
                mem_rdata <= fb[mem_addr[11:0]];
            end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [47:0] clip_rect(int x, int y, int w, int h);
        int sw = int'(scr_w);
        int sh = int'(scr_h);
        if (x + w > sw) begin x = (x < sw) ? x : sw; w = sw - x; end
        if (y + h > sh) begin y = (y < sh) ? y : sh; h = sh - y; end
        return {12'(x), 12'(y), 12'(w), 12'(h)};
    endfunction

    task automatic model_push(int x, int y, int w, int h);
        expq.push_back({12'(x), 12'(y), 12'(w), 12'(h)});
        if (expq.size() > 512) void'(expq.pop_front());
    endtask

    task automatic compare_mem(input string req);
        int bad_at = -1;
        for (int i = 0; i < FBSZ; i++)
            if (bad_at < 0 && fb[i] !== expm[i]) bad_at = i;
        if (bad_at < 0) chk(1'b1, req, 0, 0);
        else chk(1'b0, req, {bad_at, 8'(fb[bad_at])}, {bad_at, 8'(expm[bad_at])});
    endtask

    // Issue one command, wait for done; returns cycles from accept and writes seen.
    task automatic run_op(input bit op, input int sx, input int sy, input int dx, input int dy,
                          input int w, input int h, input int bpp, input logic [31:0] c,
                          output int cyc, output int wes, output bit busy_ok);
        int wb;
        int rb = w * bpp;
        logic [7:0] tmp[$];
        if (op == 1'b0) begin
            for (int r = 0; r < h; r++)
                for (int b = 0; b < rb; b++)
                    expm[(bpp * dx + PITCH * (dy + r) + b) % FBSZ] = c[8 * (b % bpp) +: 8];
        end else begin
            for (int r = 0; r < h; r++)
                for (int b = 0; b < rb; b++)
                    tmp.push_back(expm[(bpp * sx + PITCH * (sy + r) + b) % FBSZ]);
            for (int r = 0; r < h; r++)
                for (int b = 0; b < rb; b++)
                    expm[(bpp * dx + PITCH * (dy + r) + b) % FBSZ] = tmp[r * rb + b];
        end
        model_push(dx, dy, w, h);
        @(negedge clk);
        cmd_op = op; cmd_src_x = 12'(sx); cmd_src_y = 12'(sy);
        cmd_dst_x = 12'(dx); cmd_dst_y = 12'(dy); cmd_w = 12'(w); cmd_h = 12'(h);
        cfg_bpp = 3'(bpp); cmd_colour = c; cmd_valid = 1'b1;
        wb = we_cnt;
        @(negedge clk);
        cmd_valid = 1'b0;
        cyc = 1;
        busy_ok = 1'b1;
        while (!done && cyc < 50000) begin
            if (!busy || cmd_ready) busy_ok = 1'b0;
            @(negedge clk);
            cyc++;
        end
        wes = we_cnt - wb;
    endtask

    task automatic drain_check(input string req, input int cycles);
        logic [47:0] got[$];
        int mism = -1;
        @(negedge clk);
        drain_en = 1'b1;
        repeat (cycles) begin
            @(negedge clk);
            if (drain_valid) got.push_back({drain_x, drain_y, drain_w, drain_h});
        end
        drain_en = 1'b0;
        chk(got.size() == expq.size(), {req, " count"}, got.size(), expq.size());
        for (int i = 0; i < got.size() && i < expq.size(); i++) begin
            logic [47:0] e = clip_rect(int'(expq[i][47:36]), int'(expq[i][35:24]),
                                       int'(expq[i][23:12]), int'(expq[i][11:0]));
            if (mism < 0 && got[i] !== e) mism = i;
        end
        if (mism < 0) chk(1'b1, req, 0, 0);
        else chk(1'b0, req, got[mism], clip_rect(int'(expq[mism][47:36]), int'(expq[mism][35:24]),
                                                  int'(expq[mism][23:12]), int'(expq[mism][11:0])));
        expq.delete();
    endtask

    task automatic t_reset;
        chk(cmd_ready && !busy && !done && !drain_valid, "R5 reset state",
            {cmd_ready, busy, done, drain_valid}, 4'b1000);
        compare_mem("R1 preset pattern");
    endtask

    task automatic t_fill;
        int cyc, wes; bit bok;
        run_op(1'b0, 0, 0, 2, 1, 3, 2, 3, 32'hAABBCCDD, cyc, wes, bok);
        compare_mem("R1 fill bpp3");
        chk(cyc == 19, "R5 fill done timing", cyc, 19);
        chk(bok, "R5 busy held", bok, 1);
        run_op(1'b0, 0, 0, 0, 5, 2, 3, 4, 32'h11223344, cyc, wes, bok);
        compare_mem("R1 fill bpp4");
        run_op(1'b0, 0, 0, 9, 9, 5, 1, 1, 32'h0000005A, cyc, wes, bok);
        compare_mem("R1 fill bpp1");
        chk(wes == 5, "R1 fill write count", wes, 5);
    endtask

    task automatic t_copy;
        int cyc, wes; bit bok;
        run_op(1'b1, 0, 2, 1, 4, 4, 4, 2, 0, cyc, wes, bok);
        compare_mem("R2 copy overlap downward");
        chk(cyc == 2 * 32 + 1, "R5 copy done timing", cyc, 65);
        run_op(1'b1, 2, 6, 1, 3, 5, 5, 1, 0, cyc, wes, bok);
        compare_mem("R3 copy overlap upward");
        run_op(1'b1, 1, 12, 3, 12, 8, 2, 1, 0, cyc, wes, bok);
        compare_mem("R3 copy same rows rightward");
        run_op(1'b1, 4, 14, 1, 14, 3, 2, 2, 0, cyc, wes, bok);
        compare_mem("R3 copy same rows leftward");
    endtask

    task automatic t_zero;
        int cyc, wes; bit bok;
        run_op(1'b0, 0, 0, 3, 3, 0, 4, 2, 32'hFFFFFFFF, cyc, wes, bok);
        chk(wes == 0 && cyc == 1, "R4 zero width", {wes, cyc}, 1);
        run_op(1'b1, 0, 0, 3, 3, 4, 0, 1, 0, cyc, wes, bok);
        chk(wes == 0 && cyc == 1, "R4 zero height", {wes, cyc}, 1);
        compare_mem("R4 memory untouched");
    endtask

    task automatic t_drain_basic;
        drain_check("R6 R7 queued rects in order", 20);
    endtask

    task automatic t_clip;
        int cyc, wes; bit bok;
        run_op(1'b0, 0, 0, 18, 2, 5, 0, 1, 0, cyc, wes, bok);
        run_op(1'b0, 0, 0, 0, 8, 0, 6, 1, 0, cyc, wes, bok);
        run_op(1'b0, 0, 0, 25, 15, 3, 0, 1, 0, cyc, wes, bok);
        chk(clip_rect(18, 2, 5, 0) == {12'd18, 12'd2, 12'd2, 12'd0}, "R8 bench rule", 0, 0);
        drain_check("R8 clipped on drain", 8);
    endtask

    task automatic t_invalidate;
        int cyc, wes; bit bok;
        run_op(1'b0, 0, 0, 1, 1, 0, 0, 1, 0, cyc, wes, bok);
        run_op(1'b0, 0, 0, 2, 2, 0, 0, 1, 0, cyc, wes, bok);
        @(negedge clk);
        invalidate = 1'b1;
        @(negedge clk);
        invalidate = 1'b0;
        expq.delete();
        drain_check("R10 invalidate empties", 6);
        run_op(1'b0, 0, 0, 4, 4, 0, 0, 1, 0, cyc, wes, bok);
        // Push of the next command lands on the same edge as invalidate.
        expq.delete();
        @(negedge clk);
        cmd_op = 1'b0; cmd_dst_x = 12'd7; cmd_dst_y = 12'd3; cmd_w = 12'd0; cmd_h = 12'd2;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(done == 1'b1, "R4 done one cycle after accept", done, 1);
        invalidate = 1'b1;
        @(negedge clk);
        invalidate = 1'b0;
        model_push(7, 3, 0, 2);
        drain_check("R10 same-edge push kept", 6);
    endtask

    task automatic t_overflow;
        int cyc, wes; bit bok;
        scr_w = 12'd4000; scr_h = 12'd4000;
        for (int i = 0; i < 515; i++)
            run_op(1'b0, 0, 0, i, 1, 0, 0, 1, 0, cyc, wes, bok);
        chk(expq.size() == 512, "R9 bench model size", expq.size(), 512);
        drain_check("R9 oldest overwritten", 520);
        scr_w = 12'd20; scr_h = 12'd12;
    endtask

    initial begin
        for (int i = 0; i < FBSZ; i++) expm[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_fill();
        t_copy();
        t_zero();
        t_drain_basic();
        t_clip();
        t_invalidate();
        t_overflow();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule